// File: doc/BRIEF.md
# Link Self-Test Wrapper with Signature Readout

This wrapper sits around a synchronising transmit/receive link core and gives it a built-in self test. Outside a test session it is transparent. The functional transmit byte gets Hamming check bits and is registered on its way to the core. During a session, a pseudo-random generator supplies a fixed number of transmit bytes instead. Two multiple-input signature registers compress what the core produces: one takes the accumulator words it reads back on the transmit clock, and the other takes the receive output on the receive clock.

All pattern generation and compaction run at link speed on their own clocks. The test clock only starts a session, sees it finish and reads the outcome. The start level and the pattern count cross into each link domain through two-flop synchronisers. A completion flag crosses back to the test clock the same way. When the session is done, the test-access controller pulses capture. Both signatures, the core's status byte and its two error counters are then loaded into one 56-bit serial register and shifted out least significant bit first.

The link-side streams have no back-pressure. `acc_rd` and `rx_valid` act as valid strobes that the wrapper always accepts on the clock edge where they are high. The transmit word is produced every transmit cycle, and `tx_is_bist` marks the words that come from the generator.

Top module: `lnk_bist_wrap`

## Requirements
- R1: While each domain is in reset, `tx_word`, `tx_is_bist`, `bist_done` and `dr_tdo` are all 0.
- R2: Each code word is 12 bits. Code position p (1..12) is held in bit p-1. Even-parity check bits sit at positions 1, 2, 4 and 8. Data bits d0..d7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order. Every generator word obeys this code.
- R3: A session emits exactly `pat_cnt` generator words, on consecutive transmit cycles, with `tx_is_bist` high. The first data byte is 0x01. Each following byte is the previous one shifted left by one place, XORed with 0x71 when the bit shifted out was 1.
- R4: A `pat_cnt` of 0 emits no generator word, yet the session still completes and raises `bist_done`.
- R5: Outside generator words, `tx_word` is the R2 encoding of `func_data` sampled at the previous transmit edge, and `tx_is_bist` is 0.
- R6: The transmit signature is set to 0xFFFF when a session starts. On each later transmit edge with `acc_rd` high, it is shifted left one place, XORed with 0x100B if the outgoing bit 15 was 1, then XORed with `acc_data`. Otherwise it holds its value.
- R7: The receive signature is set to 0xFFFF when a session starts. On each later receive edge with `rx_valid` high, it follows the same step, with `rx_data` entering the low byte and zeros above it. Otherwise it holds its value.
- R8: `bist_done` rises only after the last generator word has been emitted. It falls again after `bist_run` is lowered.
- R9: A capture loads the chain. Bit 0 holds the transmit signature bit 0. Next come the receive signature, then `link_status`, then `data_errs`, then `sync_errs` in bits 55:48. Each shift cycle moves the chain one place toward `dr_tdo`, and `dr_tdi` enters at bit 55.
- R10: When neither capture nor shift is asserted, `dr_tdo` holds its value.
- R11: A repeated session with the same stimulus reproduces the same chain contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-clock domain reset, active low |
| bist_run | input | 1 | Session enable level (test-clock domain) |
| pat_cnt | input | CNT_W | Number of generator words per session |
| bist_done | output | 1 | Session complete, synchronised to tck |
| dr_capture | input | 1 | Load the result chain |
| dr_shift | input | 1 | Shift the result chain one place |
| dr_tdi | input | 1 | Serial input to the chain's top bit |
| dr_tdo | output | 1 | Serial output, chain bit 0 |
| tx_clk | input | 1 | Transmit link clock |
| tx_rst_n | input | 1 | Transmit domain reset, active low |
| func_data | input | 8 | Functional transmit byte |
| tx_word | output | 12 | Encoded word to the link core |
| tx_is_bist | output | 1 | Current word comes from the generator |
| acc_rd | input | 1 | Accumulator read strobe |
| acc_data | input | 16 | Accumulator read word |
| rx_clk | input | 1 | Receive link clock |
| rx_rst_n | input | 1 | Receive domain reset, active low |
| rx_valid | input | 1 | Receive output strobe |
| rx_data | input | 8 | Receive output byte |
| link_status | input | 8 | Core status byte |
| data_errs | input | 8 | Core data error count |
| sync_errs | input | 8 | Core sync error count |

## Verification
The assertions assume that `pat_cnt` is stable before `bist_run` rises, so the synchronised count is never caught mid-change. They also assume that the signatures, status and error counts do not move while a capture is taken after `bist_done`. The stimulus sets the count and the core-side bytes before each session starts. It pushes accumulator and receive words only after enough link cycles for the start to have crossed, and stops before done is polled. It captures only when done is seen, so the cross-domain values it loads are settled.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int DW     = 8;
  localparam int CW     = 12;
  localparam int SW     = 16;
  localparam logic [DW-1:0] GEN_TAPS = 8'h71;
  localparam logic [DW-1:0] GEN_SEED = 8'h01;
  localparam logic [SW-1:0] CMP_TAPS = 16'h100B;
  localparam logic [SW-1:0] CMP_INIT = 16'hFFFF;

  function automatic logic [DW-1:0] gen_step(input logic [DW-1:0] s);
    return {s[DW-2:0], 1'b0} ^ (s[DW-1] ? GEN_TAPS : '0);
  endfunction

  function automatic logic [SW-1:0] cmp_step(input logic [SW-1:0] m,
                                             input logic [SW-1:0] d);
    return ({m[SW-2:0], 1'b0} ^ (m[SW-1] ? CMP_TAPS : '0)) ^ d;
  endfunction

  // Hamming(12,8): code position p lives in bit p-1
  function automatic logic [CW-1:0] ham_enc(input logic [DW-1:0] d);
    logic [CW-1:0] w;
    w[2]  = d[0];
    w[4]  = d[1];
    w[5]  = d[2];
    w[6]  = d[3];
    w[8]  = d[4];
    w[9]  = d[5];
    w[10] = d[6];
    w[11] = d[7];
    w[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    w[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    w[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
    w[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
    return w;
  endfunction
endpackage

// File: rtl/lb_sync.sv
module lb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lb_tx_gen.sv
module lb_tx_gen
  import lb_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_s,
  input  logic [CNT_W-1:0] cnt_s,
  input  logic [DW-1:0]    func_data,
  input  logic             acc_rd,
  input  logic [SW-1:0]    acc_data,
  output logic [CW-1:0]    tx_word,
  output logic             tx_is_bist,
  output logic             done,
  output logic [SW-1:0]    sig,
  output logic             start
);
  logic             run_q;
  logic             active;
  logic [CNT_W-1:0] left;
  logic [DW-1:0]    lfsr;
  logic             emit;

  assign start = run_s & ~run_q;
  assign emit  = active && (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      active     <= 1'b0;
      left       <= '0;
      lfsr       <= GEN_SEED;
      done       <= 1'b0;
      tx_word    <= '0;
      tx_is_bist <= 1'b0;
      sig        <= CMP_INIT;
    end else begin
      run_q      <= run_s;
      tx_word    <= ham_enc(emit ? lfsr : func_data);
      tx_is_bist <= emit;
      if (!run_s) begin
        active <= 1'b0;
        done   <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        left   <= cnt_s;
        lfsr   <= GEN_SEED;
        done   <= 1'b0;
      end else if (active) begin
        if (left == '0) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          left <= left - 1'b1;
          lfsr <= gen_step(lfsr);
        end
      end
      if (start)
        sig <= CMP_INIT;
      else if (run_s && acc_rd)
        sig <= cmp_step(sig, acc_data);
    end
  end
endmodule

// File: rtl/lb_rx_cmp.sv
module lb_rx_cmp
  import lb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_s,
  input  logic          valid,
  input  logic [DW-1:0] data,
  output logic [SW-1:0] sig,
  output logic          start
);
  logic run_q;

  assign start = run_s & ~run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sig   <= CMP_INIT;
    end else begin
      run_q <= run_s;
      if (start)
        sig <= CMP_INIT;
      else if (run_s && valid)
        sig <= cmp_step(sig, {{(SW-DW){1'b0}}, data});
    end
  end
endmodule

// File: rtl/lb_scan_chain.sv
module lb_scan_chain #(
  parameter int LEN = 56
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           shift,
  input  logic           tdi,
  input  logic [LEN-1:0] par,
  output logic           tdo
);
  logic [LEN-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (capture) sr <= par;
    else if (shift)   sr <= {tdi, sr[LEN-1:1]};
  end

  assign tdo = sr[0];
endmodule

// File: rtl/lnk_bist_wrap.sv
module lnk_bist_wrap
  import lb_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BW    = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             bist_run,
  input  logic [CNT_W-1:0] pat_cnt,
  output logic             bist_done,
  input  logic             dr_capture,
  input  logic             dr_shift,
  input  logic             dr_tdi,
  output logic             dr_tdo,
  input  logic             tx_clk,
  input  logic             tx_rst_n,
  input  logic [DW-1:0]    func_data,
  output logic [CW-1:0]    tx_word,
  output logic             tx_is_bist,
  input  logic             acc_rd,
  input  logic [SW-1:0]    acc_data,
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic [BW-1:0]    link_status,
  input  logic [BW-1:0]    data_errs,
  input  logic [BW-1:0]    sync_errs
);
  localparam int CHAIN_LEN = 2 * SW + 3 * BW;

  logic             tx_run_s, rx_run_s, tx_done;
  logic [CNT_W-1:0] tx_cnt_s;
  logic [SW-1:0]    tx_sig, rx_sig;
  logic             tx_start, rx_start;

  lb_sync #(.W(1))     u_run_tx (.clk(tx_clk), .rst_n(tx_rst_n), .d(bist_run), .q(tx_run_s));
  lb_sync #(.W(CNT_W)) u_cnt_tx (.clk(tx_clk), .rst_n(tx_rst_n), .d(pat_cnt),  .q(tx_cnt_s));
  lb_sync #(.W(1))     u_run_rx (.clk(rx_clk), .rst_n(rx_rst_n), .d(bist_run), .q(rx_run_s));
  lb_sync #(.W(1))     u_done   (.clk(tck),    .rst_n(trst_n),   .d(tx_done),  .q(bist_done));

  lb_tx_gen #(.CNT_W(CNT_W)) u_tx (
    .clk(tx_clk), .rst_n(tx_rst_n), .run_s(tx_run_s), .cnt_s(tx_cnt_s),
    .func_data(func_data), .acc_rd(acc_rd), .acc_data(acc_data),
    .tx_word(tx_word), .tx_is_bist(tx_is_bist), .done(tx_done),
    .sig(tx_sig), .start(tx_start)
  );

  lb_rx_cmp u_rx (
    .clk(rx_clk), .rst_n(rx_rst_n), .run_s(rx_run_s), .valid(rx_valid),
    .data(rx_data), .sig(rx_sig), .start(rx_start)
  );

  lb_scan_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk(tck), .rst_n(trst_n), .capture(dr_capture), .shift(dr_shift),
    .tdi(dr_tdi), .par({sync_errs, data_errs, link_status, rx_sig, tx_sig}),
    .tdo(dr_tdo)
  );
endmodule

// File: rtl/lnk_bist_chk.sv
module lnk_bist_chk (
  input logic        tck,
  input logic        trst_n,
  input logic        dr_capture,
  input logic        dr_shift,
  input logic        dr_tdo,
  input logic        tx_clk,
  input logic        tx_rst_n,
  input logic [7:0]  func_data,
  input logic [11:0] tx_word,
  input logic        tx_is_bist,
  input logic        acc_rd,
  input logic        rx_clk,
  input logic        rx_rst_n,
  input logic        rx_valid,
  input logic [15:0] tx_sig,
  input logic [15:0] rx_sig,
  input logic        tx_start,
  input logic        rx_start
);
  logic tx_up;

  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) tx_up <= 1'b0;
    else           tx_up <= 1'b1;
  end

  function automatic logic [3:0] syndrome(input logic [11:0] w);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= 12; p++)
      for (int k = 0; k < 4; k++)
        if (p[k]) s[k] = s[k] ^ w[p-1];
    return s;
  endfunction

  function automatic logic [7:0] data_of(input logic [11:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  // R2
  a_r2_code_valid: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    tx_is_bist |-> syndrome(tx_word) == 4'd0);

  // R5
  a_r5_transparent: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (tx_up && !tx_is_bist) |-> data_of(tx_word) == $past(func_data));

  // R6
  a_r6_tx_sig_hold: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (!acc_rd && !tx_start) |=> $stable(tx_sig));

  // R7
  a_r7_rx_sig_hold: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (!rx_valid && !rx_start) |=> $stable(rx_sig));

  // R10
  a_r10_tdo_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (!dr_capture && !dr_shift) |=> $stable(dr_tdo));
endmodule

bind lnk_bist_wrap lnk_bist_chk u_chk (
  .tck(tck), .trst_n(trst_n), .dr_capture(dr_capture), .dr_shift(dr_shift),
  .dr_tdo(dr_tdo), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .func_data(func_data),
  .tx_word(tx_word), .tx_is_bist(tx_is_bist), .acc_rd(acc_rd),
  .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_valid(rx_valid),
  .tx_sig(tx_sig), .rx_sig(rx_sig), .tx_start(tx_start), .rx_start(rx_start)
);

// File: tb/lnk_bist_wrap_test.sv
module lnk_bist_wrap_test;
  localparam int TCK_PERIOD = 20;
  localparam int TX_PERIOD  = 8;
  localparam int RX_PERIOD  = 11;
  localparam int WD_LIMIT   = 100000;
  localparam int NV         = 5;
  // {cnt[55:40], nacc[39:32], nrx[31:24], seed[23:16], status[15:8], rx stride[7:0]}
  localparam logic [55:0] VECS [NV] = '{
    {16'd1,   8'd1,  8'd1,  8'h3C, 8'h81, 8'h01},
    {16'd5,   8'd3,  8'd4,  8'hA7, 8'h10, 8'h05},
    {16'd0,   8'd0,  8'd0,  8'h00, 8'h00, 8'h00},
    {16'd255, 8'd12, 8'd9,  8'h5E, 8'hC3, 8'h11},
    {16'd300, 8'd20, 8'd16, 8'hF0, 8'h7E, 8'h29}
  };

  logic tck = 0, tx_clk = 0, rx_clk = 0;
  logic trst_n = 0, tx_rst_n = 0, rx_rst_n = 0;
  logic bist_run = 0;
  logic [9:0] pat_cnt = '0;
  logic dr_capture = 0, dr_shift = 0, dr_tdi = 0;
  logic [7:0] func_data = '0;
  logic acc_rd = 0;
  logic [15:0] acc_data = '0;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic [7:0] link_status = '0, data_errs = '0, sync_errs = '0;
  logic bist_done, dr_tdo, tx_is_bist;
  logic [11:0] tx_word;

  always #(TCK_PERIOD/2) tck = ~tck;
  always #(TX_PERIOD/2)  tx_clk = ~tx_clk;
  always #(RX_PERIOD/2)  rx_clk = ~rx_clk;

  lnk_bist_wrap uut (
    .tck(tck), .trst_n(trst_n), .bist_run(bist_run), .pat_cnt(pat_cnt),
    .bist_done(bist_done), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_tdi(dr_tdi), .dr_tdo(dr_tdo), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n),
    .func_data(func_data), .tx_word(tx_word), .tx_is_bist(tx_is_bist),
    .acc_rd(acc_rd), .acc_data(acc_data), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .link_status(link_status),
    .data_errs(data_errs), .sync_errs(sync_errs)
  );

  int n_checks = 0, n_fail = 0, wd = 0;
  logic [11:0] words [512];
  int widx = 0;

  always @(negedge tx_clk) if (tx_is_bist) begin
    if (widx < 512) words[widx] = tx_word;
    widx++;
  end

  always @(posedge tck) begin
    wd++;
    if (wd >= WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", wd, WD_LIMIT);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] m_ham(input logic [7:0] d);
    logic [11:0] w = '0;
    int j = 0;
    for (int p = 1; p <= 12; p++)
      if ((p & (p - 1)) != 0) begin w[p-1] = d[j]; j++; end
    for (int k = 0; k < 4; k++) begin
      logic par = 0;
      for (int p = 1; p <= 12; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) par ^= w[p-1];
      w[(1 << k) - 1] = par;
    end
    return w;
  endfunction

  function automatic logic [7:0] m_gen(input logic [7:0] s);
    logic [7:0] n = s << 1;
    if (s[7]) n = n ^ 8'b0111_0001;
    return n;
  endfunction

  function automatic logic [15:0] m_cmp(input logic [15:0] m, input logic [15:0] d);
    logic [15:0] n = m << 1;
    if (m[15]) n = n ^ 16'h100B;
    return n ^ d;
  endfunction

  task automatic scan(input bit do_cap, input logic [55:0] tin, output logic [55:0] got);
    if (do_cap) begin
      @(negedge tck) dr_capture = 1;
      @(negedge tck) dr_capture = 0;
    end
    for (int i = 0; i < 56; i++) begin
      dr_tdi   = tin[i];
      dr_shift = 1;
      got[i]   = dr_tdo;
      @(negedge tck);
    end
    dr_shift = 0;
    dr_tdi   = 0;
  endtask

  task automatic run_vec(input logic [55:0] v, output logic [55:0] chain);
    int cnt = int'(v[55:40]);
    int nacc = int'(v[39:32]);
    int nrx = int'(v[31:24]);
    logic [7:0] seed = v[23:16];
    logic [7:0] stride = v[7:0];
    logic [15:0] etx = 16'hFFFF, erx = 16'hFFFF;
    logic [7:0] g = 8'h01;
    logic [55:0] exp_chain;
    pat_cnt     = cnt[9:0];
    link_status = v[15:8];
    data_errs   = seed ^ 8'h5A;
    sync_errs   = ~seed;
    widx        = 0;
    @(negedge tck) bist_run = 1;
    repeat (8) @(negedge tx_clk);
    for (int i = 0; i < nacc; i++) begin
      acc_rd   = 1;
      acc_data = {seed, i[7:0]};
      etx      = m_cmp(etx, {seed, i[7:0]});
      @(negedge tx_clk);
    end
    acc_rd = 0;
    repeat (4) @(negedge rx_clk);
    for (int i = 0; i < nrx; i++) begin
      logic [7:0] b = seed + 8'(i) * stride;
      rx_valid = 1;
      rx_data  = b;
      erx      = m_cmp(erx, {8'h00, b});
      @(negedge rx_clk);
    end
    rx_valid = 0;
    while (!bist_done) @(negedge tck);
    // R3 / R4 / R8: word count complete once done is seen
    chk(widx == cnt, cnt == 0 ? "R4 no words for zero count" : "R3 R8 word count at done",
        64'(widx), 64'(cnt));
    for (int i = 0; i < cnt && i < 512; i++) begin
      chk(words[i] == m_ham(g), "R2 R3 generator word", 64'(words[i]), 64'(m_ham(g)));
      g = m_gen(g);
    end
    exp_chain = {~seed, seed ^ 8'h5A, v[15:8], erx, etx};
    scan(1'b1, '0, chain);
    chk(chain[15:0] == etx, "R6 tx signature", 64'(chain[15:0]), 64'(etx));
    chk(chain[31:16] == erx, "R7 rx signature", 64'(chain[31:16]), 64'(erx));
    chk(chain[55:32] == exp_chain[55:32], "R9 status and counters",
        64'(chain[55:32]), 64'(exp_chain[55:32]));
    @(negedge tck) bist_run = 0;
    repeat (12) @(negedge tck);
    chk(bist_done == 1'b0, "R8 done clears", 64'(bist_done), 64'd0);
  endtask

  initial begin
    logic [55:0] c, c1, back, first_v1;
    repeat (3) @(negedge tck);
    // R1 reset state
    chk(tx_word == 12'd0, "R1 tx_word in reset", 64'(tx_word), 64'd0);
    chk(tx_is_bist == 1'b0, "R1 tx_is_bist in reset", 64'(tx_is_bist), 64'd0);
    chk(bist_done == 1'b0, "R1 done in reset", 64'(bist_done), 64'd0);
    chk(dr_tdo == 1'b0, "R1 tdo in reset", 64'(dr_tdo), 64'd0);
    trst_n = 1; tx_rst_n = 1; rx_rst_n = 1;
    repeat (2) @(negedge tck);

    // R5 transparent path
    foreach (VECS[k]) begin
      logic [7:0] d = VECS[k][23:16] ^ 8'h96;
      @(negedge tx_clk) func_data = d;
      @(negedge tx_clk);
      chk(tx_word == m_ham(d) && !tx_is_bist, "R5 normal word",
          64'({tx_is_bist, tx_word}), 64'(m_ham(d)));
    end

    first_v1 = '0;
    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k], c);
      if (k == 1) first_v1 = c;
      if (k == 0) begin
        // R9 tdi enters the top and reaches tdo after the full chain length
        scan(1'b0, 56'hC3_5A_0F_F0_96_A5_E1, back);
        scan(1'b0, '0, c1);
        chk(c1 == 56'hC3_5A_0F_F0_96_A5_E1, "R9 tdi passthrough",
            64'(c1), 64'h00C3_5A0F_F096_A5E1);
      end
    end

    // R10 tdo holds without capture or shift
    scan(1'b0, 56'h1, back);
    c1[0] = dr_tdo;
    repeat (6) @(negedge tck);
    chk(dr_tdo == c1[0], "R10 tdo hold", 64'(dr_tdo), 64'(c1[0]));

    // R11 repeated session gives the same chain
    run_vec(VECS[1], c);
    chk(c == first_v1, "R11 repeat session", 64'(c), 64'(first_v1));

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule